// File: doc/BRIEF.md
# Down-Counting Event Timer with Register Access

This block is a single-channel event timer on a simple word-wide peripheral access port. Software writes a 64-bit start value as two 32-bit halves. It then sets the enable, mode and interrupt-unmask bits in a control word. The counter decrements on each timer tick strobe, which is supplied as a one-cycle enable in the bus clock domain. Both halves of the live count can be read back at any time.

Two counting modes are available. In the free-running mode the counter reloads itself on every expiry, so it suits periodic events. In the one-shot mode it expires once and then rests at zero, which suits a programmed next-event deadline. Each expiry sets a sticky status bit that software clears by writing 1. The interrupt line is that status bit qualified by the unmask bit.

Top module: `event_timer`

## Requirements
- R1: Registers are decoded from byte address bits [4:2]. Load low is at 0x00, load high at 0x04, live count low at 0x08, live count high at 0x0C, and status (bit 0) at 0x18. The control word is at 0x10 when parameter CTRL_ALT=0 and at 0x1C when CTRL_ALT=1. Control keeps only bits [2:0]. Every other offset, including the unused control slot, reads as zero, and after reset every register reads zero.
- R2: After reset, or after any cycle with enable clear, the clock edge that follows a write setting enable loads the counter from {load high, load low}. The loaded value can be read one cycle after that write.
- R3: While enabled and loaded, the counter drops by one (with borrow across the halves) on each clock edge where tick is 1. It does not change on edges without tick.
- R4: With control bit 1 = 0 (free-running), the counter is at zero on the Nth tick after a load of N, and expiry comes on tick N+1. On that tick the counter reloads from the load registers, so the period is N+1 ticks.
- R5: With control bit 1 = 1 (one-shot), the counter expires on tick N+1 after a load of N and then holds at zero. Later ticks raise no further expiry until enable is cleared and set again.
- R6: Every expiry sets the status bit, whether or not the interrupt is unmasked. The irq output is high exactly while status is 1 and control bit 2 (unmask) is 1.
- R7: Writing 1 to status bit 0 clears the status bit. Writing 0 leaves it unchanged.
- R8: When a status-clear write and an expiry fall on the same clock edge, the status bit ends up set.
- R9: Writing 0 to control (bit 0 = enable) stops counting. The counter keeps its value through ticks while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick strobe, one clock wide |
| acc_en | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | BUS_W | Write data |
| acc_rdata | output | BUS_W | Read data, combinational while a read is presented, else zero |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can happen on the same clock edge: an expiry that sets the status bit, and a software write that clears it. The bench steps the counter down to zero. It then issues the write-1-to-clear on the same cycle as the tick that expires the count. After that edge it reads status and expects 1, and it also expects the counter to have reloaded. A separate clear with no tick pending confirms the write on its own still clears.

// File: rtl/event_timer.sv
module event_timer #(
  parameter int  BUS_W    = 32,
  parameter int  ADDR_W   = 5,
  parameter bit  CTRL_ALT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BUS_W-1:0]  acc_wdata,
  output logic [BUS_W-1:0]  acc_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [2:0] W_LD_LO  = 3'd0;
  localparam logic [2:0] W_LD_HI  = 3'd1;
  localparam logic [2:0] W_CUR_LO = 3'd2;
  localparam logic [2:0] W_CUR_HI = 3'd3;
  localparam logic [2:0] W_STAT   = 3'd6;
  localparam logic [2:0] W_CTRL   = CTRL_ALT ? 3'd7 : 3'd4;

  logic [BUS_W-1:0] load_lo, load_hi;
  logic [CNT_W-1:0] cnt;
  logic en, oneshot, unmask, status, need_load, done;

  wire [2:0]       word     = acc_addr[4:2];
  wire             wr       = acc_en & acc_write;
  wire [CNT_W-1:0] load_val = {load_hi, load_lo};
  wire             running  = en & ~need_load;
  wire             at_zero  = (cnt == '0);
  wire             expire   = running & tick & at_zero & ~done;
  wire             clr      = wr & (word == W_STAT) & acc_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_lo <= '0;
      load_hi <= '0;
      {unmask, oneshot, en} <= 3'b000;
    end else if (wr) begin
      if (word == W_LD_LO) load_lo <= acc_wdata;
      if (word == W_LD_HI) load_hi <= acc_wdata;
      if (word == W_CTRL)  {unmask, oneshot, en} <= acc_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      need_load <= 1'b1;
      done      <= 1'b0;
    end else begin
      if (!en) begin
        need_load <= 1'b1;
        done      <= 1'b0;
      end else if (need_load) begin
        need_load <= 1'b0;
        cnt       <= load_val;
      end else if (expire) begin
        if (oneshot) done <= 1'b1;
        else         cnt  <= load_val;
      end else if (tick && !at_zero) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= 1'b0;
    else if (expire) status <= 1'b1;
    else if (clr)    status <= 1'b0;
  end

  assign irq = status & unmask;

  always_comb begin
    acc_rdata = '0;
    if (acc_en && !acc_write) begin
      if      (word == W_LD_LO)  acc_rdata = load_lo;
      else if (word == W_LD_HI)  acc_rdata = load_hi;
      else if (word == W_CUR_LO) acc_rdata = cnt[BUS_W-1:0];
      else if (word == W_CUR_HI) acc_rdata = cnt[CNT_W-1:BUS_W];
      else if (word == W_STAT)   acc_rdata = {{(BUS_W-1){1'b0}}, status};
      else if (word == W_CTRL)   acc_rdata = {{(BUS_W-3){1'b0}}, unmask, oneshot, en};
    end
  end
endmodule

// File: rtl/event_timer_chk.sv
module event_timer_chk #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 acc_en,
  input logic                 acc_write,
  input logic [ADDR_W-1:0]    acc_addr,
  input logic [BUS_W-1:0]     acc_wdata,
  input logic                 en,
  input logic                 oneshot,
  input logic                 need_load,
  input logic                 done,
  input logic                 status,
  input logic [2*BUS_W-1:0]   cnt,
  input logic [BUS_W-1:0]     load_lo,
  input logic [BUS_W-1:0]     load_hi
);
  wire zero_tick = en && !need_load && tick && (cnt == '0) && !done;
  wire clr_req   = acc_en && acc_write && (acc_addr[4:2] == 3'd6) && acc_wdata[0];

  AST_EXPIRY_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_tick |=> status); // R6

  AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_tick && !oneshot) |=> cnt == $past({load_hi, load_lo})); // R4

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oneshot && !need_load && cnt == '0) |=> cnt == '0); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == $past(cnt)); // R9

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !need_load && !tick) |=> cnt == $past(cnt)); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr_req) |=> status); // R7

  AST_EXPIRY_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_tick && clr_req) |=> status); // R8
endmodule

bind event_timer event_timer_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .acc_en(acc_en), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .en(en), .oneshot(oneshot),
  .need_load(need_load), .done(done), .status(status), .cnt(cnt),
  .load_lo(load_lo), .load_hi(load_hi)
);

// File: tb/event_timer_tb.sv
module event_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_write = 1'b0;
  logic [4:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        irq;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  event_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .acc_en(acc_en), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq(irq)
  );

  // {addr, wdata, expected read-back}
  localparam int NV = 8;
  localparam logic [68:0] VEC [NV] = '{
    {5'h00, 32'hA5A5_0001, 32'hA5A5_0001},
    {5'h04, 32'h0000_00C3, 32'h0000_00C3},
    {5'h10, 32'h0000_00F2, 32'h0000_0002},
    {5'h14, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h1C, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h18, 32'h0000_0000, 32'h0000_0000},
    {5'h08, 32'h0000_1234, 32'h0000_0000},
    {5'h0C, 32'h0000_5678, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d, input logic t);
    acc_en = w; acc_write = w; acc_addr = a; acc_wdata = d; tick = t;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0; acc_write = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'h0, 32'h0, 1'b1);
  endtask

  task automatic idle();
    cyc(1'b0, 5'h0, 32'h0, 1'b0);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    acc_en = 1'b1; acc_write = 1'b0; acc_addr = a;
    #1 v = acc_rdata;
    acc_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 32; a += 4) begin
      rd(a[4:0], v);
      chk("R1 reset read", v, 0);
    end
    chk("R6 reset irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      chk("R1 map", v, VEC[i][31:0]);
    end
    wr(5'h10, 0);

    // free-running, N=3
    wr(5'h00, 3); wr(5'h04, 0); wr(5'h10, 5);
    idle();
    rd(5'h08, v); chk("R2 load", v, 3);
    ticks(3);
    rd(5'h08, v); chk("R4 at zero", v, 0);
    rd(5'h18, v); chk("R4 no early expiry", v, 0);
    ticks(1);
    rd(5'h18, v); chk("R4 expiry tick N+1", v, 1);
    chk("R6 irq unmasked", irq, 1);
    rd(5'h08, v); chk("R4 reload", v, 3);

    wr(5'h18, 0);
    rd(5'h18, v); chk("R7 write 0 keeps", v, 1);
    wr(5'h18, 1);
    rd(5'h18, v); chk("R7 write 1 clears", v, 0);
    chk("R7 irq drops", irq, 0);

    // masked
    wr(5'h10, 1);
    ticks(4);
    rd(5'h18, v); chk("R6 masked status", v, 1);
    chk("R6 masked irq", irq, 0);
    wr(5'h18, 1);

    // collision: clear and expiry same edge
    ticks(3);
    cyc(1'b1, 5'h18, 1, 1'b1);
    rd(5'h18, v); chk("R8 expiry wins", v, 1);
    rd(5'h08, v); chk("R8 reload", v, 3);
    wr(5'h18, 1);
    rd(5'h18, v); chk("R8 later clear", v, 0);

    // disable holds, re-enable reloads
    ticks(1);
    wr(5'h10, 0);
    ticks(2);
    rd(5'h08, v); chk("R9 hold disabled", v, 2);
    rd(5'h18, v); chk("R9 no expiry", v, 0);
    wr(5'h10, 1);
    idle();
    rd(5'h08, v); chk("R2 reload on enable", v, 3);

    // 64-bit value
    wr(5'h10, 0);
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 1);
    wr(5'h10, 1);
    idle();
    rd(5'h08, v); chk("R2 load lo", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R2 load hi", v, 1);
    ticks(1);
    rd(5'h08, v); chk("R3 decrement", v, 32'hFFFF_FFFE);
    idle(); idle();
    rd(5'h08, v); chk("R3 no tick hold", v, 32'hFFFF_FFFE);
    wr(5'h10, 0);
    wr(5'h00, 0); wr(5'h04, 1);
    wr(5'h10, 1);
    idle();
    ticks(1);
    rd(5'h08, v); chk("R3 borrow lo", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R3 borrow hi", v, 0);

    // one-shot, N=2
    wr(5'h10, 0);
    wr(5'h00, 2); wr(5'h04, 0);
    wr(5'h10, 7);
    rd(5'h10, v); chk("R1 control read", v, 7);
    idle();
    ticks(2);
    rd(5'h18, v); chk("R5 not yet", v, 0);
    ticks(1);
    rd(5'h18, v); chk("R5 expiry", v, 1);
    chk("R5 irq", irq, 1);
    rd(5'h08, v); chk("R5 hold zero", v, 0);
    wr(5'h18, 1);
    ticks(3);
    rd(5'h18, v); chk("R5 single expiry", v, 0);
    rd(5'h08, v); chk("R5 stays zero", v, 0);
    chk("R5 irq quiet", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule